// File: doc/BRIEF.md
# Programmable Horizontal Sample Timer

This block sets the moments inside each video line at which a pixel is sampled. A base tick, one clock-enable pulse per 100 ns step, drives every count. When a horizontal sync pulse arrives, the block waits a programmed number of ticks (the lead) and then produces a fixed number of sample strobes. By default it produces 64 strobes, spaced a programmed number of ticks apart (the pitch). After the last strobe it closes its sampling window and stays quiet until the next sync.

A large pitch spreads the samples across the whole active line, which gives a zoomed-out view. A small pitch with a chosen lead packs the samples around one position, which gives a zoomed-in and panned view.

The lead and pitch come from CPU-written configuration inputs. They reach the line logic only through shadow copies, which are captured on a field-start pulse, so one field is always sampled with one consistent setting. The block moves no pixel data. It has no stream interface and so no valid/ready handshake or back-pressure: every pin is a plain control or status level or pulse.

Top module: `hsample_timer`

## Requirements
- R1: After a sync, an uninterrupted line yields exactly SAMPLES (default 64) strobes. After that, no strobe appears until the next sync.
- R2: Ticks are numbered from 0.
  - Tick 0 is the first tick in a cycle after the sync cycle. A tick in the sync cycle itself is not counted.
  - Sample j (j = 0 .. SAMPLES-1) is taken on tick number lead + j*pitch.
- R3: A strobe is high for exactly the one cycle after the tick that qualifies it. It never appears without a tick in the cycle before.
- R4: A pitch value of 0 behaves exactly like a pitch of 1.
- R5: The window output is high from the cycle of the first strobe through the cycle of the last strobe of the line. It is low at all other times.
- R6: A sync restarts the lead count and the sample count.
  - In the cycle after a sync, both the strobe and the window are low.
  - A line that is still unfinished when a sync arrives is abandoned.
- R7: The lead and pitch used by a line come from shadow copies, which load from the configuration inputs only on a field-start pulse. A change to the configuration inputs without a field-start has no effect on later lines.
- R8: When field-start and sync fall in the same cycle, the line that sync begins already uses the newly loaded values.
- R9: A field-start during a line does not change the timing of that line. The new values apply from the next sync on.
- R10: After reset both outputs are low, and no strobe appears before the first sync. The shadow copies reset to lead 0 and pitch 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base step enable, one cycle per 100 ns unit |
| hsync | input | 1 | One-cycle line start pulse |
| field_start | input | 1 | One-cycle field start pulse; loads the shadow copies |
| cfg_offset | input | OFF_W (10) | CPU setting: lead in ticks before the first sample |
| cfg_period | input | PER_W (8) | CPU setting: pitch in ticks between samples (0 means 1) |
| sample_strobe | output | 1 | One-cycle pulse per sample |
| window_active | output | 1 | High from the first to the last sample of the line |

## Verification
Two functions can fall in the same cycle: the shadow load on field-start and the line restart on sync. The bench drives both pulses together and expects the new line to follow the values on the configuration inputs. It also pulses field-start alone in the middle of a line and expects that line to keep its old timing. A tick that lands in the sync cycle is a second coincidence; the bench provokes it through random tick placement and expects that tick to be ignored. All cases are judged cycle by cycle against strobe and window sequences the bench computes from the lead + j*pitch rule.

// File: rtl/hst_pkg.sv
package hst_pkg;
  typedef enum logic [1:0] {
    HST_IDLE = 2'd0,
    HST_LEAD = 2'd1,
    HST_RUN  = 2'd2
  } hst_mode_e;
endpackage

// File: rtl/hst_shadow_regs.sv
module hst_shadow_regs #(
  parameter int OFF_W = 10,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic [OFF_W-1:0] cfg_offset,
  input  logic [PER_W-1:0] cfg_period,
  output logic [OFF_W-1:0] eff_offset,
  output logic [PER_W-1:0] eff_period
);
  logic [OFF_W-1:0] sh_off;
  logic [PER_W-1:0] sh_per;
  logic [PER_W-1:0] raw_per;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_off <= '0;
      sh_per <= '0;
    end else if (field_start) begin
      sh_off <= cfg_offset;
      sh_per <= cfg_period;
    end
  end

  // a field start coinciding with sync feeds the fresh values straight through
  always_comb begin
    eff_offset = field_start ? cfg_offset : sh_off;
    raw_per    = field_start ? cfg_period : sh_per;
    eff_period = (raw_per == '0) ? PER_W'(1) : raw_per;
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> ($stable(sh_off) && $stable(sh_per))); // R7

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (sh_off == $past(cfg_offset) && sh_per == $past(cfg_period))); // R7
endmodule

// File: rtl/hst_line_sequencer.sv
module hst_line_sequencer
  import hst_pkg::*;
#(
  parameter int OFF_W   = 10,
  parameter int PER_W   = 8,
  parameter int SAMPLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hsync,
  input  logic [OFF_W-1:0] line_offset,
  input  logic [PER_W-1:0] line_period,
  output logic             strobe,
  output logic             window
);
  localparam int CNT_W = $clog2(SAMPLES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SAMPLES - 1);
  localparam hst_mode_e AFTER_FIRST = (SAMPLES == 1) ? HST_IDLE : HST_RUN;

  hst_mode_e        mode;
  logic [OFF_W-1:0] lead_cnt;
  logic [PER_W-1:0] gap_cnt;
  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] samp_cnt;
  logic             strobe_q;
  logic             win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= HST_IDLE;
      lead_cnt <= '0;
      gap_cnt  <= '0;
      per_q    <= PER_W'(1);
      samp_cnt <= '0;
      strobe_q <= 1'b0;
      win_q    <= 1'b0;
    end else if (hsync) begin
      // restart or abort: tick in this cycle is consumed by the restart
      mode     <= HST_LEAD;
      lead_cnt <= line_offset;
      per_q    <= line_period;
      gap_cnt  <= '0;
      samp_cnt <= '0;
      strobe_q <= 1'b0;
      win_q    <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      unique case (mode)
        HST_LEAD: begin
          if (tick) begin
            if (lead_cnt == '0) begin
              strobe_q <= 1'b1;
              win_q    <= 1'b1;
              samp_cnt <= CNT_W'(1);
              gap_cnt  <= per_q - PER_W'(1);
              mode     <= AFTER_FIRST;
            end else begin
              lead_cnt <= lead_cnt - OFF_W'(1);
            end
          end
        end
        HST_RUN: begin
          if (tick) begin
            if (gap_cnt == '0) begin
              strobe_q <= 1'b1;
              samp_cnt <= samp_cnt + CNT_W'(1);
              gap_cnt  <= per_q - PER_W'(1);
              if (samp_cnt == LAST_IDX) mode <= HST_IDLE;
            end else begin
              gap_cnt <= gap_cnt - PER_W'(1);
            end
          end
        end
        default: begin
          win_q <= 1'b0;
        end
      endcase
    end
  end

  assign strobe = strobe_q;
  assign window = win_q;

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $past(tick)); // R3

  AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> win_q); // R5

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (!strobe_q && !win_q)); // R6

  AST_SAMPLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    samp_cnt <= CNT_W'(SAMPLES)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HST_IDLE && !hsync) |=> !strobe_q); // R1
endmodule

// File: rtl/hsample_timer.sv
module hsample_timer #(
  parameter int OFF_W   = 10,
  parameter int PER_W   = 8,
  parameter int SAMPLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hsync,
  input  logic             field_start,
  input  logic [OFF_W-1:0] cfg_offset,
  input  logic [PER_W-1:0] cfg_period,
  output logic             sample_strobe,
  output logic             window_active
);
  logic [OFF_W-1:0] eff_offset;
  logic [PER_W-1:0] eff_period;

  hst_shadow_regs #(.OFF_W(OFF_W), .PER_W(PER_W)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .cfg_offset  (cfg_offset),
    .cfg_period  (cfg_period),
    .eff_offset  (eff_offset),
    .eff_period  (eff_period)
  );

  hst_line_sequencer #(.OFF_W(OFF_W), .PER_W(PER_W), .SAMPLES(SAMPLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .hsync       (hsync),
    .line_offset (eff_offset),
    .line_period (eff_period),
    .strobe      (sample_strobe),
    .window      (window_active)
  );
endmodule

// File: tb/hsample_timer_tb.sv
module hsample_timer_tb_top;
  localparam int OFF_W   = 10;
  localparam int PER_W   = 8;
  localparam int SAMPLES = 64;
  localparam int CLK_NS  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             hsync = 1'b0;
  logic             field_start = 1'b0;
  logic [OFF_W-1:0] cfg_offset = '0;
  logic [PER_W-1:0] cfg_period = '0;
  logic             sample_strobe;
  logic             window_active;

  int n_cmp = 0;
  int n_mis = 0;
  bit finished = 0;
  int sh_off_b = 0;
  int sh_per_b = 0;

  always #(CLK_NS/2) clk = ~clk;

  hsample_timer #(.OFF_W(OFF_W), .PER_W(PER_W), .SAMPLES(SAMPLES)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .hsync         (hsync),
    .field_start   (field_start),
    .cfg_offset    (cfg_offset),
    .cfg_period    (cfg_period),
    .sample_strobe (sample_strobe),
    .window_active (window_active)
  );

  function automatic bit is_sample(input int k, input int off, input int per);
    if (k < off) return 0;
    if (((k - off) % per) != 0) return 0;
    return ((k - off) / per) < SAMPLES;
  endfunction

  function automatic bit rnd_tick(input int pct);
    return ($urandom_range(99) < pct);
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s act=%0b exp=%0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic load_field();
    field_start = 1'b1; hsync = 1'b0; tick = 1'b0;
    @(posedge clk); @(negedge clk);
    field_start = 1'b0;
    sh_off_b = int'(cfg_offset);
    sh_per_b = int'(cfg_period);
  endtask

  // fs_at: -1 none, 0 together with sync, >0 during the line at that cycle
  // max_cyc: 0 runs the full line, >0 aborts after that many cycles
  task automatic run_line(input int pct, input int fs_at, input int max_cyc, input string tag);
    int off, per, last_k, k, nstrobe, tail;
    bit opened, closed, fin_prev, s, fin, ew, t;
    off = (fs_at == 0) ? int'(cfg_offset) : sh_off_b;
    per = (fs_at == 0) ? int'(cfg_period) : sh_per_b;
    if (per == 0) per = 1;
    last_k = off + (SAMPLES - 1) * per;
    hsync = 1'b1;
    field_start = (fs_at == 0);
    tick = rnd_tick(pct);
    @(posedge clk); @(negedge clk);
    chk(sample_strobe, 1'b0, {"R6 strobe after sync ", tag});
    chk(window_active, 1'b0, {"R6 window after sync ", tag});
    if (fs_at == 0) begin
      sh_off_b = int'(cfg_offset);
      sh_per_b = int'(cfg_period);
    end
    k = 0; opened = 0; closed = 0; fin_prev = 0; nstrobe = 0; tail = 0;
    for (int c = 1; c < 30000; c++) begin
      hsync = 1'b0;
      field_start = (c == fs_at);
      t = rnd_tick(pct);
      tick = t;
      if (fin_prev) closed = 1;
      s = t && is_sample(k, off, per);
      if (t && k == off) opened = 1;
      fin = s && (k == last_k);
      if (t) k++;
      ew = opened && !closed;
      fin_prev = fin;
      @(posedge clk); @(negedge clk);
      chk(sample_strobe, s, {"R2 R3 strobe ", tag});
      chk(window_active, ew, {"R5 window ", tag});
      if (sample_strobe) nstrobe++;
      if (c == fs_at) begin
        sh_off_b = int'(cfg_offset);
        sh_per_b = int'(cfg_period);
      end
      if (max_cyc > 0 && c >= max_cyc) break;
      if (closed) begin
        tail++;
        if (tail >= 3) break;
      end
    end
    field_start = 1'b0;
    if (max_cyc == 0) chk_int(nstrobe, SAMPLES, {"R1 strobe count ", tag});
  endtask

  initial begin
    void'($urandom(32'd731));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: quiet after reset with ticks but no sync
    for (int i = 0; i < 12; i++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(sample_strobe, 1'b0, "R10 reset strobe");
      chk(window_active, 1'b0, "R10 reset window");
    end
    // R10: reset shadows are lead 0, pitch 0 (acts as 1)
    run_line(100, -1, 0, "R10 R4 reset shadow");
    // R7: field start alone then a line
    cfg_offset = 10'd5; cfg_period = 8'd3;
    load_field();
    run_line(100, -1, 0, "R7 directed");
    // R8: coincident field start and sync, random lines
    for (int i = 0; i < 6; i++) begin
      cfg_offset = OFF_W'($urandom_range(40));
      cfg_period = PER_W'($urandom_range(6));
      run_line(30 + int'($urandom_range(70)), 0, 0, "R8 random");
    end
    // R4: pitch zero
    cfg_offset = 10'd2; cfg_period = 8'd0;
    run_line(60, 0, 0, "R4 pitch zero");
    // R2: lead zero, tick every cycle
    cfg_offset = 10'd0; cfg_period = 8'd2;
    run_line(100, 0, 0, "R2 lead zero");
    // R7: config change without field start has no effect
    cfg_offset = 10'd33; cfg_period = 8'd5;
    run_line(70, -1, 0, "R7 no load");
    // R9: field start inside a line; current line keeps old timing
    run_line(80, 50, 0, "R9 mid-line load");
    run_line(80, -1, 0, "R9 next line");
    // R6: abort mid-line, then a clean line
    cfg_offset = 10'd4; cfg_period = 8'd6;
    run_line(90, 0, 40, "R6 abort");
    run_line(90, -1, 0, "R6 after abort");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      n_cmp++;
      n_mis++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end
endmodule